// File: doc/BRIEF.md
# Programmable Host Interrupt Generator

This block drives one active-high interrupt line for a peripheral whose host side is a byte-wide file of 32 registers at addresses 0x00 to 0x1F. Two fixed sources come from the receive datapath. Each is a buffer-ready flag, and each has its own enable bit and its own status bit. A host that wants an interrupt for either buffer sets the matching enable bit. It then services the interrupt and writes a zero to the status bit to drop it.

A third source can be programmed. The host picks any register in the file by its address and gives an 8-bit mask. It then chooses one of two tests on the masked bits: "all masked bits set" or "any masked bit set". A trigger mode decides how the result reaches the status bit. In level mode the status bit simply tracks the result. In edge mode the status bit is latched when the result goes from false to true, and it holds until the host clears it. The interrupt line is the OR of the three status bits.

Top module: `hirq_top`

## Requirements
- R1: After reset every register reads 0x00 and `irq` is low.
- R2: A host write stores the byte in any register other than 0x1F. The stored byte reads back on `host_rdata`, which combinationally follows `host_addr`.
- R3: A rising edge on `buf1_ready` while enable bit 2 of register 0x1E is 1 sets status bit 0 of register 0x1F and raises `irq` at the same clock edge.
- R4: A rising edge on `buf2_ready` while enable bit 5 of register 0x1E is 1 sets status bit 1 of register 0x1F and raises `irq`.
- R5: While an enable bit is 0, a rising edge on its buffer-ready input leaves its status bit and `irq` unchanged.
- R6: A host write to 0x1F clears each status bit written as 0 and leaves each bit written as 1 as it was. A source set in the same cycle as a clear wins. Bits 7:3 of 0x1F read 0.
- R7: The programmable condition is false while bit 6 of register 0x0A is 0.
- R8: When bit 5 of 0x0A is 0 (any-bit mode), the condition is true if the register addressed by 0x0C[4:0], ANDed with the mask in 0x0D, is non-zero.
- R9: When bit 5 of 0x0A is 1 (all-bits mode), the condition is true if every mask bit is set in the addressed register. A zero mask makes the condition true in all-bits mode and false in any-bit mode.
- R10: When bit 7 of 0x0A is 0 (level mode), status bit 2 of 0x1F takes the condition's value one clock after it changes. In this mode a host clear has no lasting effect.
- R11: When bit 7 of 0x0A is 1 (edge mode), status bit 2 is set on a false-to-true change of the condition. It stays set, even if the condition falls, until the host writes 0 to it.
- R12: `irq` is high exactly when at least one of status bits 0, 1 and 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 5 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Contents of the addressed register |
| buf1_ready | input | 1 | Buffer 1 data-ready flag |
| buf2_ready | input | 1 | Buffer 2 data-ready flag |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two functions can fall in one clock cycle: a source setting a status bit, and a host write of zero clearing that same bit. The bench provokes this by raising `buf1_ready` on the same edge as a write of 0x00 to register 0x1F. It then requires status bit 0 and `irq` to be set, and it also shows that a later clear with no event does take effect. A second collision occurs in edge mode. There the bench moves the condition false, clears the latch, and clears again while the condition stays true. It requires that the latch stays clear until a new rising edge of the condition.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int NREG   = 1 << ADDR_W;
    localparam int NSTAT  = 3;

    localparam logic [ADDR_W-1:0] ADR_MODE  = 5'h0A;
    localparam logic [ADDR_W-1:0] ADR_WATCH = 5'h0C;
    localparam logic [ADDR_W-1:0] ADR_MASK  = 5'h0D;
    localparam logic [ADDR_W-1:0] ADR_ENA   = 5'h1E;
    localparam logic [ADDR_W-1:0] ADR_STAT  = 5'h1F;

    localparam int BIT_EN1  = 2;
    localparam int BIT_EN2  = 5;
    localparam int BIT_ALLM = 5;
    localparam int BIT_PEN  = 6;
    localparam int BIT_EDGE = 7;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic              all_mode;
        logic              prog_en;
        logic              edge_mode;
        logic [1:0]        src_en;
        logic [ADDR_W-1:0] watch;
        byte_t             mask;
    } ctl_t;

    function automatic logic mask_match(input byte_t val, input byte_t msk,
                                        input logic all_mode);
        if (all_mode) return (val & msk) == msk;
        return |(val & msk);
    endfunction
endpackage

// File: rtl/hirq_regfile.sv
module hirq_regfile
    import hirq_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  byte_t                        wdata,
    output logic [NREG-1:0][DATA_W-1:0]  regs,
    output ctl_t                         ctl
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && addr == ADDR_W'(g))
                regs[g] <= wdata;
        end
    end

    always_comb begin
        ctl.all_mode  = regs[ADR_MODE][BIT_ALLM];
        ctl.prog_en   = regs[ADR_MODE][BIT_PEN];
        ctl.edge_mode = regs[ADR_MODE][BIT_EDGE];
        ctl.src_en    = {regs[ADR_ENA][BIT_EN2], regs[ADR_ENA][BIT_EN1]};
        ctl.watch     = regs[ADR_WATCH][ADDR_W-1:0];
        ctl.mask      = regs[ADR_MASK];
    end

    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && addr != ADR_STAT) |=> regs[$past(addr)] == $past(wdata));
endmodule

// File: rtl/hirq_fixed_src.sv
module hirq_fixed_src (
    input  logic clk,
    input  logic rst,
    input  logic flag,
    input  logic en,
    input  logic clr,
    output logic stat
);
    logic flag_q;
    logic event_hit;

    assign event_hit = flag && !flag_q && en;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            stat   <= 1'b0;
        end else begin
            flag_q <= flag;
            if (event_hit)
                stat <= 1'b1;
            else if (clr)
                stat <= 1'b0;
        end
    end

    a_r3_set_on_rise: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_q && en) |=> stat);
    a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        (!stat && !en) |=> !stat);
    a_r6_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (clr && !(flag && !flag_q && en)) |=> !stat);
endmodule

// File: rtl/hirq_prog_src.sv
module hirq_prog_src
    import hirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  ctl,
    input  byte_t watched,
    input  logic  clr,
    output logic  stat
);
    logic cond;
    logic cond_q;

    assign cond = ctl.prog_en && mask_match(watched, ctl.mask, ctl.all_mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= 1'b0;
            stat   <= 1'b0;
        end else begin
            cond_q <= cond;
            if (!ctl.edge_mode)
                stat <= cond;
            else if (cond && !cond_q)
                stat <= 1'b1;
            else if (clr)
                stat <= 1'b0;
        end
    end

    a_r7_disabled_level: assert property (@(posedge clk) disable iff (rst)
        (!ctl.prog_en && !ctl.edge_mode) |=> !stat);
    a_r11_edge_sets: assert property (@(posedge clk) disable iff (rst)
        (ctl.edge_mode && cond && !cond_q) |=> stat);
    a_r11_edge_holds: assert property (@(posedge clk) disable iff (rst)
        (ctl.edge_mode && stat && !clr) |=> stat);
endmodule

// File: rtl/hirq_top.sv
module hirq_top
    import hirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              buf1_ready,
    input  logic              buf2_ready,
    output logic              irq
);
    logic [NREG-1:0][DATA_W-1:0] regs;
    ctl_t                        ctl;
    logic [NSTAT-1:0]            stat;
    logic [NSTAT-1:0]            clr;
    logic [1:0]                  flags;
    byte_t                       watched;

    function automatic byte_t view(input logic [ADDR_W-1:0] a,
                                   input logic [NREG-1:0][DATA_W-1:0] r,
                                   input logic [NSTAT-1:0] s);
        if (a == ADR_STAT) return byte_t'(s);
        return r[a];
    endfunction

    hirq_regfile u_regs (
        .clk(clk), .rst(rst), .we(host_we), .addr(host_addr),
        .wdata(host_wdata), .regs(regs), .ctl(ctl)
    );

    assign flags = {buf2_ready, buf1_ready};
    for (genvar i = 0; i < NSTAT; i++) begin : g_clr
        assign clr[i] = host_we && host_addr == ADR_STAT && !host_wdata[i];
    end

    for (genvar i = 0; i < 2; i++) begin : g_fixed
        hirq_fixed_src u_src (
            .clk(clk), .rst(rst), .flag(flags[i]), .en(ctl.src_en[i]),
            .clr(clr[i]), .stat(stat[i])
        );
    end

    assign watched = view(ctl.watch, regs, stat);

    hirq_prog_src u_prog (
        .clk(clk), .rst(rst), .ctl(ctl), .watched(watched),
        .clr(clr[2]), .stat(stat[2])
    );

    assign host_rdata = view(host_addr, regs, stat);
    assign irq        = |stat;

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !irq);
    a_r12_irq_drop: assert property (@(posedge clk) disable iff (rst)
        (irq && clr == {NSTAT{1'b1}} && !ctl.edge_mode && !(|flags)) |=> !stat[0] && !stat[1]);
endmodule

// File: tb/tb_hirq_top.sv
`timescale 1ns/1ps
module tb_hirq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_we = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       buf1_ready = 1'b0;
    logic       buf2_ready = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [4:0] a;
        logic [7:0] d;
        logic       i;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    hirq_top dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .buf1_ready(buf1_ready), .buf2_ready(buf2_ready), .irq(irq)
    );

    // monitor: compares just before the next rising edge
    always begin
        @(negedge clk);
        #2;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (host_rdata !== e.d || irq !== e.i) begin
                errors++;
                $display("FAIL %s: reg %02h got %02h irq %0b, expected %02h irq %0b",
                         e.tag, e.a, host_rdata, irq, e.d, e.i);
            end
        end
    end

    task automatic expect_reg(input logic [4:0] a, input logic [7:0] d,
                              input logic i, input string tag);
        exp_t e;
        @(negedge clk);
        host_we   = 1'b0;
        host_addr = a;
        e.a = a; e.d = d; e.i = i; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 1) buf1_ready = 1'b1; else buf2_ready = 1'b1;
        @(negedge clk);
        buf1_ready = 1'b0; buf2_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_reg(5'h1F, 8'h00, 1'b0, "R1 status");
        expect_reg(5'h0A, 8'h00, 1'b0, "R1 mode");
        expect_reg(5'h1E, 8'h00, 1'b0, "R1 enable");

        wr(5'h05, 8'hA5); expect_reg(5'h05, 8'hA5, 1'b0, "R2 reg05");
        wr(5'h13, 8'h3C); expect_reg(5'h13, 8'h3C, 1'b0, "R2 reg13");

        pulse(1); expect_reg(5'h1F, 8'h00, 1'b0, "R5 src1 disabled");
        pulse(2); expect_reg(5'h1F, 8'h00, 1'b0, "R5 src2 disabled");

        wr(5'h1E, 8'h24);
        pulse(1); expect_reg(5'h1F, 8'h01, 1'b1, "R3 src1 set");
        wr(5'h1F, 8'hFF); expect_reg(5'h1F, 8'h01, 1'b1, "R6 write ones keeps");
        wr(5'h1F, 8'h00); expect_reg(5'h1F, 8'h00, 1'b0, "R6 clear");
        pulse(2); expect_reg(5'h1F, 8'h02, 1'b1, "R4 src2 set");
        wr(5'h1F, 8'h00); expect_reg(5'h1F, 8'h00, 1'b0, "R6 clear src2");

        // set and clear in one cycle: set wins
        @(negedge clk);
        host_we = 1'b1; host_addr = 5'h1F; host_wdata = 8'h00; buf1_ready = 1'b1;
        @(negedge clk);
        host_we = 1'b0; buf1_ready = 1'b0;
        expect_reg(5'h1F, 8'h01, 1'b1, "R6 set beats clear");
        wr(5'h1F, 8'h00); expect_reg(5'h1F, 8'h00, 1'b0, "R6 later clear");

        // programmable source: watch reg 05 (A5)
        wr(5'h0C, 8'h05); wr(5'h0D, 8'h41);
        expect_reg(5'h1F, 8'h00, 1'b0, "R7 prog disabled");
        wr(5'h0D, 8'h42); wr(5'h0A, 8'h40);
        expect_reg(5'h1F, 8'h00, 1'b0, "R8 any-bit no match");
        wr(5'h0D, 8'h41);
        expect_reg(5'h1F, 8'h04, 1'b1, "R8 any-bit match");
        wr(5'h0A, 8'h60);
        expect_reg(5'h1F, 8'h00, 1'b0, "R9 all-bits partial");
        wr(5'h0D, 8'h21);
        expect_reg(5'h1F, 8'h04, 1'b1, "R9 all-bits full");
        wr(5'h0D, 8'h00);
        expect_reg(5'h1F, 8'h04, 1'b1, "R9 zero mask all-bits true");
        wr(5'h0A, 8'h40);
        expect_reg(5'h1F, 8'h00, 1'b0, "R9 zero mask any-bit false");

        wr(5'h0A, 8'h60); wr(5'h0D, 8'h21);
        wr(5'h1F, 8'h00);
        expect_reg(5'h1F, 8'h04, 1'b1, "R10 level ignores clear");
        wr(5'h05, 8'h00);
        expect_reg(5'h1F, 8'h00, 1'b0, "R10 level follows fall");

        wr(5'h0A, 8'hE0);
        expect_reg(5'h1F, 8'h00, 1'b0, "R11 edge idle");
        wr(5'h05, 8'h21);
        expect_reg(5'h1F, 8'h04, 1'b1, "R11 edge set");
        wr(5'h05, 8'h00);
        expect_reg(5'h1F, 8'h04, 1'b1, "R11 edge held");
        wr(5'h1F, 8'h00);
        expect_reg(5'h1F, 8'h00, 1'b0, "R11 edge cleared");

        wr(5'h05, 8'h21);
        expect_reg(5'h1F, 8'h04, 1'b1, "R11 edge set again");
        pulse(1);
        expect_reg(5'h1F, 8'h05, 1'b1, "R12 two sources");
        wr(5'h1F, 8'hFE);
        expect_reg(5'h1F, 8'h04, 1'b1, "R12 one left");
        wr(5'h1F, 8'hFB);
        expect_reg(5'h1F, 8'h00, 1'b0, "R12 none left, condition still true");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule